// File: doc/BRIEF.md
# ADC Result Register Flag Controller

This block sits between an analog-to-digital converter front end and the register bus of a chip. Each finished conversion arrives as a channel index plus a 10-bit result. The block stores that result in the data register of its channel and in a shared last-result register. It also records which channel converted last. It keeps one end-of-conversion flag per channel and one global data-ready flag. Software clears these flags by reading the registers: a channel data read clears that channel's flag, and a last-result read clears data-ready together with the flag of the channel recorded as last.

Overrun bits report results that were overwritten before they were read. A request pulse to a DMA engine marks each rising edge of data-ready. An interrupt line is formed from the status bits through a writable mask. The conversion input is a valid/ready stream. `conv_ready` is low during reset and rises on the first clock after reset, then stays high. The block never applies back-pressure, so the converter may present one result per cycle. A result is taken on each rising edge where both `conv_valid` and `conv_ready` are high.

Top module: `adc_result_flags`

## Requirements
- R1: After reset every data register, flag, overrun bit, the last-channel index and the mask read as zero, `irq` and `dma_req` are low, and `conv_ready` is high from the first clock after reset.
- R2: An accepted result is written to the data register of its channel, read at address `ch` (0 to 7, bits [9:0]). It is also written to the last-result register at address 8, which returns the result in bits [9:0] and the channel index in bits [18:16].
- R3: An accepted result sets the channel's end-of-conversion bit (status bit `ch`) and data-ready (status bit 16) at the same edge. The status register is at address 9.
- R4: A read is issued by `rd_en` with `rd_addr`, and `rd_data` holds the value on the next cycle. A read of channel data register `c` clears status bit `c` only.
- R5: A read of address 8 clears data-ready and the end-of-conversion bit of the last converted channel. All other end-of-conversion bits keep their values.
- R6: When a result for a channel is accepted in the same cycle as a read that would clear that channel's flag or data-ready, the flag is 1 after the edge.
- R7: An accepted result whose channel flag is already set sets the channel overrun bit (status bit 8+`ch`). An accepted result while data-ready is set sets the general overrun bit (status bit 17). A status read returns the values held before the edge and then clears all overrun bits.
- R8: While `dma_en` is high, `dma_req` is high for exactly the one cycle in which data-ready goes from 0 to 1. It stays low when a result arrives while data-ready is already 1, and it stays low when `dma_en` is low.
- R9: The mask register at address 10 has the status layout, is readable and is written by `wr_en`. `irq` is the OR of status AND mask. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | Conversion result present |
| conv_ready | output | 1 | Block accepts results (high after reset) |
| conv_ch | input | 3 | Channel index of the result |
| conv_data | input | 10 | Conversion result |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 18 | Write data (mask layout) |
| dma_en | input | 1 | A DMA channel is attached |
| dma_req | output | 1 | One-cycle transfer request |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a result and a clearing read landing on the same edge, because software reads and converter completions are unrelated in time. The bench drives the case directly: one task raises `conv_valid` and `rd_en` in the same cycle, once with the channel's own data address and once with the last-result address. It then reads status to confirm that the set won and that the overrun bits captured the collision. A table of channel and result pairs is walked afterwards to cover every channel through the full set and clear cycle.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;
  typedef enum logic [2:0] {RK_NONE, RK_CHAN, RK_LAST, RK_STAT, RK_MASK} acc_kind_e;

  // Map: channels at 0..nch-1, last result, status, mask follow in that order.
  function automatic acc_kind_e classify(input int unsigned addr, input int unsigned nch);
    if (addr < nch)          return RK_CHAN;
    else if (addr == nch)    return RK_LAST;
    else if (addr == nch+1)  return RK_STAT;
    else if (addr == nch+2)  return RK_MASK;
    else                     return RK_NONE;
  endfunction
endpackage

// File: rtl/adc_rf_store.sv
module adc_rf_store #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  input  logic [DATA_W-1:0] take_data,
  output logic [DATA_W-1:0] ch_data [NUM_CH],
  output logic [DATA_W-1:0] last_data
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ch_data[g] <= '0;
      else if (take && take_ch == CH_W'(g))      ch_data[g] <= take_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_data <= '0;
    else if (take) last_data <= take_data;
  end
endmodule

// File: rtl/adc_rf_flags.sv
module adc_rf_flags #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  input  logic              clr_chan,
  input  logic [CH_W-1:0]   clr_idx,
  input  logic              clr_last,
  input  logic              clr_ovr,
  output logic [NUM_CH-1:0] eoc,
  output logic [NUM_CH-1:0] ovr,
  output logic              drdy,
  output logic              govr,
  output logic [CH_W-1:0]   last_ch,
  output logic              drdy_rise
);
  logic [NUM_CH-1:0] eoc_n, ovr_n;
  logic              drdy_n, govr_n;
  logic [CH_W-1:0]   last_n;

  always_comb begin
    eoc_n  = eoc;
    drdy_n = drdy;
    ovr_n  = clr_ovr ? '0 : ovr;
    govr_n = clr_ovr ? 1'b0 : govr;
    last_n = last_ch;
    // clears first, sets after: a set in the same cycle wins
    if (clr_chan) eoc_n[clr_idx] = 1'b0;
    if (clr_last) begin
      eoc_n[last_ch] = 1'b0;
      drdy_n         = 1'b0;
    end
    if (take) begin
      if (eoc[take_ch]) ovr_n[take_ch] = 1'b1;
      if (drdy)         govr_n         = 1'b1;
      eoc_n[take_ch] = 1'b1;
      drdy_n         = 1'b1;
      last_n         = take_ch;
    end
  end

  assign drdy_rise = drdy_n & ~drdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc     <= '0;
      ovr     <= '0;
      drdy    <= 1'b0;
      govr    <= 1'b0;
      last_ch <= '0;
    end else begin
      eoc     <= eoc_n;
      ovr     <= ovr_n;
      drdy    <= drdy_n;
      govr    <= govr_n;
      last_ch <= last_n;
    end
  end
endmodule

// File: rtl/adc_rf_regif.sv
module adc_rf_regif
  import adc_rf_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 4,
  parameter int RD_W        = 32,
  parameter int LAST_CH_LSB = 16,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int STAT_W     = 2*NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] status,
  input  logic [DATA_W-1:0] ch_data [NUM_CH],
  input  logic [DATA_W-1:0] last_data,
  input  logic [CH_W-1:0]   last_ch,
  input  logic              drdy_rise,
  input  logic              dma_en,
  output logic [RD_W-1:0]   rd_data,
  output logic [STAT_W-1:0] mask,
  output logic              irq,
  output logic              dma_req,
  output logic              clr_chan,
  output logic [CH_W-1:0]   clr_idx,
  output logic              clr_last,
  output logic              clr_ovr
);
  acc_kind_e       rkind;
  logic            wr_mask;
  logic [RD_W-1:0] rd_next;

  assign rkind    = rd_en ? classify(32'(rd_addr), NUM_CH) : RK_NONE;
  assign wr_mask  = wr_en && (classify(32'(wr_addr), NUM_CH) == RK_MASK);
  assign clr_chan = (rkind == RK_CHAN);
  assign clr_idx  = rd_addr[CH_W-1:0];
  assign clr_last = (rkind == RK_LAST);
  assign clr_ovr  = (rkind == RK_STAT);

  always_comb begin
    rd_next = rd_data;
    case (rkind)
      RK_CHAN: begin
        rd_next = '0;
        rd_next[DATA_W-1:0] = ch_data[clr_idx];
      end
      RK_LAST: begin
        rd_next = '0;
        rd_next[DATA_W-1:0] = last_data;
        rd_next[LAST_CH_LSB +: CH_W] = last_ch;
      end
      RK_STAT: begin
        rd_next = '0;
        rd_next[STAT_W-1:0] = status;
      end
      RK_MASK: begin
        rd_next = '0;
        rd_next[STAT_W-1:0] = mask;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      mask    <= '0;
      dma_req <= 1'b0;
    end else begin
      rd_data <= rd_next;
      if (wr_mask) mask <= wr_data;
      dma_req <= dma_en & drdy_rise;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/adc_result_flags.sv
module adc_result_flags #(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 4,
  parameter int RD_W        = 32,
  parameter int LAST_CH_LSB = 16,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int STAT_W     = 2*NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              dma_en,
  output logic              dma_req,
  output logic              irq
);
  logic              take;
  logic [NUM_CH-1:0] eoc_q, ovr_q;
  logic              drdy_q, govr_q, drdy_rise;
  logic [CH_W-1:0]   last_ch_q, clr_idx;
  logic              clr_chan, clr_last, clr_ovr;
  logic [STAT_W-1:0] status, mask_q;
  logic [DATA_W-1:0] ch_data [NUM_CH];
  logic [DATA_W-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_ready <= 1'b0;
    else        conv_ready <= 1'b1;
  end

  assign take   = conv_valid & conv_ready;
  assign status = {govr_q, drdy_q, ovr_q, eoc_q};

  adc_rf_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n, .take, .take_ch(conv_ch), .take_data(conv_data),
    .ch_data, .last_data
  );

  adc_rf_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk, .rst_n, .take, .take_ch(conv_ch),
    .clr_chan, .clr_idx, .clr_last, .clr_ovr,
    .eoc(eoc_q), .ovr(ovr_q), .drdy(drdy_q), .govr(govr_q),
    .last_ch(last_ch_q), .drdy_rise
  );

  adc_rf_regif #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .RD_W(RD_W), .LAST_CH_LSB(LAST_CH_LSB)
  ) u_regif (
    .clk, .rst_n, .rd_en, .rd_addr, .wr_en, .wr_addr, .wr_data,
    .status, .ch_data, .last_data, .last_ch(last_ch_q),
    .drdy_rise, .dma_en, .rd_data, .mask(mask_q), .irq, .dma_req,
    .clr_chan, .clr_idx, .clr_last, .clr_ovr
  );
endmodule

// File: rtl/adc_rf_checker.sv
module adc_rf_checker #(
  parameter int NUM_CH  = 8,
  parameter int ADDR_W  = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int STAT_W = 2*NUM_CH + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic [CH_W-1:0]   conv_ch,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NUM_CH-1:0] eoc,
  input logic [NUM_CH-1:0] ovr,
  input logic              drdy,
  input logic [CH_W-1:0]   last_ch,
  input logic [STAT_W-1:0] mask,
  input logic              irq,
  input logic              dma_req
);
  logic take;
  assign take = conv_valid & conv_ready;

  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> conv_ready);

  p_last_ch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> last_ch == $past(conv_ch));

  p_eoc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> eoc[$past(conv_ch)] && drdy);

  p_chan_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr < ADDR_W'(NUM_CH) && !take) |=> !eoc[$past(rd_addr[CH_W-1:0])]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_en && rd_addr == ADDR_W'(conv_ch)) |=> eoc[$past(conv_ch)]);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && eoc[conv_ch]) |=> ovr[$past(conv_ch)]);

  p_dma_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  p_dma_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> drdy && !$past(drdy));

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind adc_result_flags adc_rf_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
  .conv_ch(conv_ch), .rd_en(rd_en), .rd_addr(rd_addr), .eoc(eoc_q), .ovr(ovr_q),
  .drdy(drdy_q), .last_ch(last_ch_q), .mask(mask_q), .irq(irq), .dma_req(dma_req)
);

// File: tb/adc_result_flags_tb.sv
module adc_result_flags_tb;
  localparam int A_LAST = 8, A_STAT = 9, A_MASK = 10;
  localparam int B_DRDY = 16, B_GOVR = 17;
  // table entry: {channel[2:0], result[9:0]}
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 10'h3FF}, {3'd7, 10'h000}, {3'd3, 10'h155}, {3'd5, 10'h2AA},
    {3'd1, 10'h001}, {3'd6, 10'h200}, {3'd2, 10'h0F0}, {3'd4, 10'h30C}};

  logic        clk = 0, rst_n = 0;
  logic        conv_valid = 0, rd_en = 0, wr_en = 0, dma_en = 0;
  logic [2:0]  conv_ch = 0;
  logic [9:0]  conv_data = 0;
  logic [3:0]  rd_addr = 0, wr_addr = 0;
  logic [17:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        conv_ready, dma_req, irq;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  adc_result_flags u_dut (
    .clk, .rst_n, .conv_valid, .conv_ready, .conv_ch, .conv_data,
    .rd_en, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data,
    .dma_en, .dma_req, .irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic conv(input logic [2:0] ch, input logic [9:0] v);
    @(negedge clk);
    conv_valid = 1; conv_ch = ch; conv_data = v;
    @(negedge clk);
    conv_valid = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0; q = rd_data;
  endtask

  task automatic conv_rd(input logic [2:0] ch, input logic [9:0] v,
                         input logic [3:0] a, output logic [31:0] q);
    @(negedge clk);
    conv_valid = 1; conv_ch = ch; conv_data = v; rd_en = 1; rd_addr = a;
    @(negedge clk);
    conv_valid = 0; rd_en = 0; q = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [17:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 conv_ready", 32'(conv_ready), 1);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    rd(4'(A_STAT), d); chk("R1 status", d, 0);
    rd(4'(A_MASK), d); chk("R1 mask", d, 0);
    rd(4'd3, d);       chk("R1 chan3", d, 0);
    rd(4'(A_LAST), d); chk("R1 last", d, 0);

    // table walk: R2 R3 R4 R5 on every channel
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c;
      logic [9:0] v;
      c = VEC[i][12:10]; v = VEC[i][9:0];
      conv(c, v);
      rd(4'(A_STAT), d); chk("R3 flags set", d, (32'd1 << c) | (32'd1 << B_DRDY));
      rd(4'(c), d);      chk("R2 chan data", d, 32'(v));
      rd(4'(A_STAT), d); chk("R4 chan clear", d, 32'd1 << B_DRDY);
      rd(4'(A_LAST), d); chk("R2 last data", d, 32'(v) | (32'(c) << 16));
      rd(4'(A_STAT), d); chk("R5 last clear", d, 0);
    end

    // R5: last read clears only the last channel's flag
    conv(3'd2, 10'h011);
    conv(3'd5, 10'h022);
    rd(4'(A_LAST), d); chk("R5 last data", d, 32'h022 | (32'd5 << 16));
    rd(4'(A_STAT), d); chk("R5 other eoc kept", d, (32'd1 << 2) | (32'd1 << B_GOVR));
    rd(4'd2, d);       chk("R4 chan2", d, 32'h011);
    rd(4'(A_STAT), d); chk("R4 status clean", d, 0);

    // R7 overrun
    conv(3'd3, 10'h100);
    conv(3'd3, 10'h101);
    rd(4'(A_STAT), d);
    chk("R7 overrun set", d, (32'd1 << 3) | (32'd1 << 11) | (32'd1 << B_DRDY) | (32'd1 << B_GOVR));
    rd(4'(A_STAT), d); chk("R7 overrun cleared", d, (32'd1 << 3) | (32'd1 << B_DRDY));
    rd(4'd3, d);       chk("R7 newest kept", d, 32'h101);
    rd(4'(A_LAST), d); chk("R7 last", d, 32'h101 | (32'd3 << 16));

    // R6 set wins against channel read
    conv(3'd1, 10'h055);
    conv_rd(3'd1, 10'h066, 4'd1, d);
    chk("R6 old data read", d, 32'h055);
    rd(4'(A_STAT), d);
    chk("R6 eoc stays", d, (32'd1 << 1) | (32'd1 << 9) | (32'd1 << B_DRDY) | (32'd1 << B_GOVR));
    rd(4'd1, d);       chk("R6 chan1 new", d, 32'h066);
    rd(4'(A_LAST), d); chk("R6 last", d, 32'h066 | (32'd1 << 16));
    rd(4'(A_STAT), d); chk("R6 clean", d, 0);

    // R6 set wins against last-result read
    conv(3'd4, 10'h0AA);
    conv_rd(3'd6, 10'h0BB, 4'(A_LAST), d);
    chk("R6 last old", d, 32'h0AA | (32'd4 << 16));
    rd(4'(A_STAT), d);
    chk("R6 drdy stays", d, (32'd1 << 6) | (32'd1 << B_DRDY) | (32'd1 << B_GOVR));
    rd(4'(A_LAST), d); chk("R6 last new", d, 32'h0BB | (32'd6 << 16));
    rd(4'(A_STAT), d); chk("R6 clean2", d, 0);

    // R8 DMA request
    dma_en = 1;
    conv(3'd0, 10'h010);
    chk("R8 dma pulse", 32'(dma_req), 1);
    @(negedge clk);
    chk("R8 dma one cycle", 32'(dma_req), 0);
    conv(3'd0, 10'h011);
    chk("R8 no pulse drdy high", 32'(dma_req), 0);
    rd(4'(A_STAT), d);
    rd(4'(A_LAST), d);
    dma_en = 0;
    conv(3'd7, 10'h012);
    chk("R8 no pulse disabled", 32'(dma_req), 0);
    rd(4'(A_LAST), d);
    rd(4'(A_STAT), d); chk("R8 clean", d, 0);

    // R9 interrupt mask
    wr(4'(A_MASK), 18'(32'd1 << B_DRDY));
    rd(4'(A_MASK), d); chk("R9 mask readback", d, 32'd1 << B_DRDY);
    chk("R9 irq idle", 32'(irq), 0);
    conv(3'd2, 10'h1C3);
    chk("R9 irq drdy", 32'(irq), 1);
    rd(4'd2, d);
    chk("R9 irq held", 32'(irq), 1);
    rd(4'(A_LAST), d);
    chk("R9 irq off", 32'(irq), 0);
    wr(4'(A_MASK), 18'(32'd1 << 5));
    conv(3'd2, 10'h1C4);
    chk("R9 unmasked source", 32'(irq), 0);
    wr(4'(A_STAT), 18'h3FFFF);
    rd(4'(A_STAT), d); chk("R9 write ignored", d, (32'd1 << 2) | (32'd1 << B_DRDY));
    rd(4'(A_MASK), d); chk("R9 mask kept", d, 32'd1 << 5);
    rd(4'(A_LAST), d);
    rd(4'(A_STAT), d); chk("R9 clean", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule